// File: doc/BRIEF.md
# Dual-Channel Cycle-Steal Memory Transfer Engine

This block is a two-channel direct memory access engine. It shares one memory bus with a processor. When a channel receives a transfer request, the engine asks a bus arbiter for the bus. Once the bus is granted, it reads one unit (a byte or a 16-bit word) from a source address and writes that unit to a destination address. It then drops its bus request, so the processor gets the bus back after every unit.

A request comes from one of two places: a software trigger bit in the channel's select register, or the rising edge of one of 32 peripheral interrupt lines. The line is chosen by a 4-bit index plus a bank bit. Interrupt-enable state plays no part in accepting a request. The engine has no outputs toward the peripherals, so their request flags are never disturbed.

Each channel keeps a working forward pointer, which advances through memory, and a 16-bit working counter. When the counter runs out, the channel either switches itself off or reloads, depending on its mode.

Top module: `dmac_top`

## Requirements
- R1: Register address `reg_addr` is {channel bit, 3-bit index}.
  - Index 0 is the source base (20 bits).
  - Index 1 is the destination base (20 bits).
  - Index 2 is the reload value (16 bits).
  - Index 3 is control: bit0 enable, bit1 word width, bit2 repeat, bit3 forward-on-destination.
  - Index 4 is select: bits 3:0 line, bit4 bank, bit5 software trigger, which always reads 0.
  - Index 5 is the working count (read-only).
  - Index 6 is the forward pointer (read-only).
  - After reset every register reads 0, and `bus_req`, `mem_rd`, `mem_wr` and `xfer_done` are 0.
- R2: While enabled, writing index 4 with bit5 set causes exactly one unit transfer. The engine reads the unit at the source address, then writes the same data to the destination address.
- R3: While enabled, a rising edge on `irq_lines[{bank,line}]` causes one transfer. Edges on other lines cause nothing.
- R4: With control bit1 set, the full 16-bit word is moved, `mem_wide` is 1 and the step is 2. With bit1 clear, the byte in bits 7:0 is moved with bits 15:8 written as 0, `mem_wide` is 0 and the step is 1.
- R5: Control bit3 chooses which side uses the forward pointer: 0 means the source side, 1 means the destination side. The other side stays at its base. The forward pointer grows by the step after each unit.
- R6: Requests that arrive while a channel is disabled are dropped. Enabling the channel later does not start a transfer.
- R7: `bus_req` rises first. No memory cycle happens before `bus_gnt`. Then come the read cycle, one idle cycle and the write cycle. `bus_req` is low in the cycle after the write.
- R8: When both channels become pending in the same cycle, channel 0 is transferred first.
- R9: Once a channel's transfer has been selected, any number of further requests before the next selection yield exactly one more transfer.
- R10: The working count drops by 1 per unit. The unit done while the count is 0 raises that channel's `xfer_done` bit for one cycle. In single mode (bit2 clear), it also clears the enable bit.
- R11: In repeat mode, that unit instead reloads the count from the reload value and moves the forward pointer back to its base. The channel stays enabled.
- R12: A control write that turns enable from 0 to 1 loads the count from the reload value. It also loads the forward pointer from the base chosen by bit3 of the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | {channel, register index} |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data for `reg_addr` (combinational) |
| irq_lines | input | 32 | Peripheral interrupt request lines |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | 20 | Memory address |
| mem_rd | output | 1 | Read strobe; data expected on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wide | output | 1 | 1 for a word access, 0 for a byte access |
| mem_rdata | input | 16 | Read data |
| mem_wdata | output | 16 | Write data |
| xfer_done | output | 2 | Per-channel pulse when a count runs out |

## Verification
The checker watches the bus protocol on every cycle:
- reads and writes never overlap;
- no memory cycle happens without both request and grant;
- every read is followed, after one idle cycle, by a write of the same width;
- the bus is released right after each write;
- at most one channel signals completion at a time.

Other behaviours depend on sequences of stimulus, so only the bench's scenarios can show them. These are the addresses and data each unit carries, the order of the two channels, the merging of surplus requests, requests dropped while disabled, and the single-mode and repeat-mode handling of count underflow.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    parameter int NUM_CH   = 2;
    parameter int AW       = 20;
    parameter int CW       = 16;
    parameter int DW       = 16;
    parameter int SEL_W    = 4;
    parameter int IDX_W    = 3;

    localparam int NLINES    = 2 ** (SEL_W + 1);
    localparam int CHB       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int RA_W      = IDX_W + CHB;
    localparam int CTRL_W    = 4;
    localparam int TRIG_BIT  = SEL_W + 1;
    localparam int BYTE_W    = DW / 2;

    localparam logic [IDX_W-1:0] REG_SRC  = 3'd0;
    localparam logic [IDX_W-1:0] REG_DST  = 3'd1;
    localparam logic [IDX_W-1:0] REG_RLD  = 3'd2;
    localparam logic [IDX_W-1:0] REG_CTRL = 3'd3;
    localparam logic [IDX_W-1:0] REG_SEL  = 3'd4;
    localparam logic [IDX_W-1:0] REG_CNT  = 3'd5;
    localparam logic [IDX_W-1:0] REG_FWD  = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_CAP,
        ST_WR,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic fwd_dst;
        logic rpt;
        logic wide;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic             bank;
        logic [SEL_W-1:0] line;
    } sel_t;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic          wide;
    } xfer_t;

    function automatic logic [AW-1:0] unit_step(input logic wide);
        return wide ? AW'(2) : AW'(1);
    endfunction

    function automatic logic [DW-1:0] fit_unit(input logic wide, input logic [DW-1:0] d);
        return wide ? d : {{(DW-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
    endfunction
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  widx,
    input  logic [AW-1:0]     wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [AW-1:0]     rdata,
    input  logic [NLINES-1:0] irq_lines,
    input  logic              svc_start,
    input  logic              unit_done,
    output logic              pend_o,
    output xfer_t             xfer_o,
    output logic              done_o
);
    ctrl_t          ctrl_q;
    sel_t           sel_q;
    logic [AW-1:0]  src_q, dst_q, fwd_q;
    logic [CW-1:0]  rld_q, cnt_q;
    logic           pend_q, line_prev_q, done_q;

    logic           line_now, hw_trig, sw_trig, trig;
    ctrl_t          ctrl_new;
    logic [AW-1:0]  base, step;

    assign line_now = irq_lines[sel_q];
    assign hw_trig  = line_now & ~line_prev_q;
    assign sw_trig  = wr_en && (widx == REG_SEL) && wdata[TRIG_BIT];
    assign trig     = hw_trig | sw_trig;
    assign ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
    assign base     = ctrl_q.fwd_dst ? dst_q : src_q;
    assign step     = unit_step(ctrl_q.wide);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            sel_q       <= '0;
            src_q       <= '0;
            dst_q       <= '0;
            fwd_q       <= '0;
            rld_q       <= '0;
            cnt_q       <= '0;
            pend_q      <= 1'b0;
            line_prev_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            line_prev_q <= line_now;
            done_q      <= 1'b0;

            if (unit_done) begin
                if (cnt_q == '0) begin
                    done_q <= 1'b1;
                    if (ctrl_q.rpt) begin
                        cnt_q <= rld_q;
                        fwd_q <= base;
                    end else begin
                        ctrl_q.en <= 1'b0;
                        fwd_q     <= fwd_q + step;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                    fwd_q <= fwd_q + step;
                end
            end

            if (wr_en) begin
                case (widx)
                    REG_SRC:  src_q <= wdata;
                    REG_DST:  dst_q <= wdata;
                    REG_RLD:  rld_q <= wdata[CW-1:0];
                    REG_CTRL: begin
                        ctrl_q <= ctrl_new;
                        if (!ctrl_q.en && ctrl_new.en) begin
                            cnt_q <= rld_q;
                            fwd_q <= ctrl_new.fwd_dst ? dst_q : src_q;
                        end
                    end
                    REG_SEL:  sel_q <= sel_t'(wdata[SEL_W:0]);
                    default: ;
                endcase
            end

            if (!ctrl_q.en)     pend_q <= 1'b0;
            else if (trig)      pend_q <= 1'b1;
            else if (svc_start) pend_q <= 1'b0;
        end
    end

    assign pend_o      = pend_q & ctrl_q.en;
    assign done_o      = done_q;
    assign xfer_o.src  = ctrl_q.fwd_dst ? src_q : fwd_q;
    assign xfer_o.dst  = ctrl_q.fwd_dst ? fwd_q : dst_q;
    assign xfer_o.wide = ctrl_q.wide;

    always_comb begin
        case (ridx)
            REG_SRC:  rdata = src_q;
            REG_DST:  rdata = dst_q;
            REG_RLD:  rdata = {{(AW-CW){1'b0}}, rld_q};
            REG_CTRL: rdata = {{(AW-CTRL_W){1'b0}}, ctrl_q};
            REG_SEL:  rdata = {{(AW-SEL_W-1){1'b0}}, sel_q};
            REG_CNT:  rdata = {{(AW-CW){1'b0}}, cnt_q};
            REG_FWD:  rdata = fwd_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb
    import dmac_pkg::*;
(
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] gnt_oh,
    output logic [CHB-1:0]    idx,
    output logic              any
);
    always_comb begin
        gnt_oh = '0;
        idx    = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_oh    = '0;
                gnt_oh[i] = 1'b1;
                idx       = CHB'(i);
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           any,
    input  logic [CHB-1:0] pick,
    input  xfer_t          xfer_in,
    input  logic           bus_gnt,
    input  logic [DW-1:0]  mem_rdata,
    output logic           svc_start,
    output logic [CHB-1:0] cur,
    output logic           unit_done,
    output logic           bus_req,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           mem_wide,
    output logic [DW-1:0]  mem_wdata
);
    seq_state_e     st_q;
    logic [CHB-1:0] cur_q;
    xfer_t          xf_q;
    logic [DW-1:0]  dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cur_q <= '0;
            xf_q  <= '0;
            dat_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (any) begin
                    st_q  <= ST_REQ;
                    cur_q <= pick;
                    xf_q  <= xfer_in;
                end
                ST_REQ:  if (bus_gnt) st_q <= ST_RD;
                ST_RD:   st_q <= ST_CAP;
                ST_CAP: begin
                    dat_q <= fit_unit(xf_q.wide, mem_rdata);
                    st_q  <= ST_WR;
                end
                ST_WR:   st_q <= ST_DONE;
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign svc_start = (st_q == ST_IDLE) && any;
    assign unit_done = (st_q == ST_DONE);
    assign cur       = cur_q;
    assign bus_req   = (st_q == ST_REQ) || (st_q == ST_RD) ||
                       (st_q == ST_CAP) || (st_q == ST_WR);
    assign mem_rd    = (st_q == ST_RD);
    assign mem_wr    = (st_q == ST_WR);
    assign mem_addr  = (st_q == ST_WR) ? xf_q.dst : xf_q.src;
    assign mem_wide  = xf_q.wide;
    assign mem_wdata = dat_q;
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic [NLINES-1:0] irq_lines,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_wide,
    input  logic [DW-1:0]     mem_rdata,
    output logic [DW-1:0]     mem_wdata,
    output logic [NUM_CH-1:0] xfer_done
);
    logic [NUM_CH-1:0] pend, gnt_oh;
    logic [CHB-1:0]    pick, cur;
    logic              any, svc_start, unit_done;
    logic [AW-1:0]     rd_arr [NUM_CH];
    xfer_t             xf_arr [NUM_CH];
    logic [CHB-1:0]    reg_ch;
    logic [IDX_W-1:0]  reg_idx;

    assign reg_ch  = reg_addr[IDX_W +: CHB];
    assign reg_idx = reg_addr[IDX_W-1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dmac_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (reg_wr && (reg_ch == CHB'(i))),
            .widx      (reg_idx),
            .wdata     (reg_wdata),
            .ridx      (reg_idx),
            .rdata     (rd_arr[i]),
            .irq_lines (irq_lines),
            .svc_start (svc_start && gnt_oh[i]),
            .unit_done (unit_done && (cur == CHB'(i))),
            .pend_o    (pend[i]),
            .xfer_o    (xf_arr[i]),
            .done_o    (xfer_done[i])
        );
    end

    dmac_arb u_arb (
        .req    (pend),
        .gnt_oh (gnt_oh),
        .idx    (pick),
        .any    (any)
    );

    dmac_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .any       (any),
        .pick      (pick),
        .xfer_in   (xf_arr[pick]),
        .bus_gnt   (bus_gnt),
        .mem_rdata (mem_rdata),
        .svc_start (svc_start),
        .cur       (cur),
        .unit_done (unit_done),
        .bus_req   (bus_req),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wide  (mem_wide),
        .mem_wdata (mem_wdata)
    );

    assign reg_rdata = rd_arr[reg_ch];
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk
    import dmac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_wide,
    input logic [NUM_CH-1:0] xfer_done
);
    // R7
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R7
    mem_needs_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (bus_req && bus_gnt));

    // R7
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (!mem_rd && !mem_wr) ##1 mem_wr);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !bus_req);

    // R4
    width_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> ##1 (mem_wide == $past(mem_wide, 2)));

    // R10
    done_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(xfer_done));
endmodule

bind dmac_top dmac_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wide  (mem_wide),
    .xfer_done (xfer_done)
);

// File: tb/tb_dmac_top.sv
module tb_dmac_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [19:0] reg_wdata = '0;
    logic [19:0] reg_rdata;
    logic [31:0] irq_lines = '0;
    logic        bus_req, bus_gnt;
    logic [19:0] mem_addr;
    logic        mem_rd, mem_wr, mem_wide;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem_wdata;
    logic [1:0]  xfer_done;
    logic        allow = 1'b1;

    always #5 clk = ~clk;

    assign bus_gnt = bus_req & allow;

    dmac_top dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wide(mem_wide),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .xfer_done(xfer_done)
    );

    function automatic logic [15:0] mem_val(input logic [19:0] a);
        return a[15:0] ^ 16'hC3A5 ^ {a[19:16], 12'h000};
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_val(mem_addr);

    typedef struct packed {
        logic        wr;
        logic [19:0] addr;
        logic [15:0] data;
        logic        wide;
    } bus_ev_t;

    bus_ev_t exp_q[$];
    string   tag_q[$];
    int      checks = 0;
    int      fails  = 0;
    int      events = 0;
    int      done0  = 0;
    int      done1  = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic logic [3:0] ra(input int ch, input int idx);
        return {ch[0], idx[2:0]};
    endfunction

    task automatic expect_unit(input logic [19:0] src, input logic [19:0] dst,
                               input logic wide, input string tag);
        logic [15:0] d;
        d = wide ? mem_val(src) : {8'h00, mem_val(src)[7:0]};
        exp_q.push_back('{wr: 1'b0, addr: src, data: 16'h0, wide: wide});
        tag_q.push_back(tag);
        exp_q.push_back('{wr: 1'b1, addr: dst, data: d, wide: wide});
        tag_q.push_back(tag);
    endtask

    // Scoreboard monitor: compares every bus cycle with the next expected one
    always @(negedge clk) begin
        if (!rst) begin
            if (xfer_done[0]) done0++;
            if (xfer_done[1]) done1++;
            if (mem_rd || mem_wr) begin
                events++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected bus cycle",
                          {3'b0, mem_wr, mem_addr, mem_wdata}, 40'h0);
                end else begin
                    bus_ev_t e;
                    string   t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check((e.wr == mem_wr) && (e.addr == mem_addr) &&
                          (e.wide == mem_wide) && (!e.wr || e.data == mem_wdata),
                          t, "bus cycle {wr,wide,addr,data}",
                          {2'b0, mem_wr, mem_wide, mem_addr, mem_wr ? mem_wdata : 16'h0},
                          {2'b0, e.wr, e.wide, e.addr, e.wr ? e.data : 16'h0});
                end
            end
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [19:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [3:0] a, input logic [19:0] exp,
                             input string tag, input string what);
        @(posedge clk); #1;
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, what, {20'h0, reg_rdata}, {20'h0, exp});
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_irq(input int line);
        @(posedge clk); #1;
        irq_lines[line] = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        irq_lines[line] = 1'b0;
    endtask

    task automatic drained(input string tag);
        check(exp_q.size() == 0, tag, "expected cycles left over",
              40'(exp_q.size()), 40'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired (all requirements): actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        int ev0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        #1;
        check(bus_req == 1'b0 && mem_rd == 1'b0 && mem_wr == 1'b0, "R1", "bus idle after reset",
              {37'h0, bus_req, mem_rd, mem_wr}, 40'h0);
        check(xfer_done == 2'b00, "R1", "done pulses after reset", 40'(xfer_done), 40'h0);
        reg_check(ra(0, 3), 20'h0, "R1", "ch0 control at reset");
        reg_check(ra(1, 5), 20'h0, "R1", "ch1 count at reset");

        // Channel 0: word, source side advances, reload 2
        reg_write(ra(0, 0), 20'h12340);
        reg_write(ra(0, 1), 20'h00800);
        reg_write(ra(0, 2), 20'h00002);
        reg_write(ra(0, 3), 20'h00003);
        reg_check(ra(0, 5), 20'h00002, "R12", "count loaded on enable");
        reg_check(ra(0, 6), 20'h12340, "R12", "forward pointer loaded on enable");

        // R2 software trigger, word width
        expect_unit(20'h12340, 20'h00800, 1'b1, "R2");
        reg_write(ra(0, 4), 20'h00020);
        settle(20);
        drained("R2");
        reg_check(ra(0, 6), 20'h12342, "R5", "source-side forward pointer step 2");
        reg_check(ra(0, 5), 20'h00001, "R10", "count decremented");
        reg_check(ra(0, 4), 20'h00000, "R1", "trigger bit reads zero");

        // R7 no memory cycle before the grant
        allow = 1'b0;
        ev0 = events;
        reg_write(ra(0, 4), 20'h00020);
        settle(8);
        #1;
        check(bus_req == 1'b1, "R7", "request held while grant withheld", 40'(bus_req), 40'h1);
        check(events == ev0, "R7", "bus cycles before grant", 40'(events - ev0), 40'h0);
        expect_unit(20'h12342, 20'h00800, 1'b1, "R7");
        allow = 1'b1;
        settle(20);
        #1;
        drained("R7");
        check(bus_req == 1'b0, "R7", "bus released after unit", 40'(bus_req), 40'h0);

        // R10 single-mode underflow
        expect_unit(20'h12344, 20'h00800, 1'b1, "R10");
        reg_write(ra(0, 4), 20'h00020);
        settle(20);
        drained("R10");
        check(done0 == 1, "R10", "ch0 completion pulses", 40'(done0), 40'h1);
        reg_check(ra(0, 3), 20'h00002, "R10", "enable cleared at underflow");

        // R6 requests while disabled are dropped
        ev0 = events;
        reg_write(ra(0, 4), 20'h00020);
        settle(10);
        reg_write(ra(0, 3), 20'h00003);
        settle(20);
        check(events == ev0, "R6", "bus cycles from dropped request", 40'(events - ev0), 40'h0);

        // Channel 1: byte, destination side advances, line {bank1, 3} = 19
        reg_write(ra(1, 0), 20'h00050);
        reg_write(ra(1, 1), 20'h40000);
        reg_write(ra(1, 2), 20'h00005);
        reg_write(ra(1, 4), 20'h00013);
        reg_write(ra(1, 3), 20'h00009);
        ev0 = events;
        pulse_irq(2);
        pulse_irq(3);
        settle(15);
        check(events == ev0, "R3", "unselected lines ignored", 40'(events - ev0), 40'h0);
        expect_unit(20'h00050, 20'h40000, 1'b0, "R3");
        pulse_irq(19);
        settle(20);
        drained("R3");
        expect_unit(20'h00050, 20'h40001, 1'b0, "R4");
        pulse_irq(19);
        settle(20);
        drained("R4");
        reg_check(ra(1, 6), 20'h40002, "R5", "destination-side forward pointer step 1");
        reg_check(ra(1, 0), 20'h00050, "R5", "source base unchanged");

        // R8 both pending in one cycle: channel 0 first
        expect_unit(20'h12340, 20'h00800, 1'b1, "R8");
        expect_unit(20'h00050, 20'h40002, 1'b0, "R8");
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = ra(0, 4); reg_wdata = 20'h00020;
        irq_lines[19] = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        settle(30);
        #1 irq_lines[19] = 1'b0;
        drained("R8");

        // R9 merge, with R11 repeat-mode underflow
        reg_write(ra(0, 3), 20'h00007);
        allow = 1'b0;
        ev0 = events;
        reg_write(ra(0, 4), 20'h00020);
        settle(2);
        reg_write(ra(0, 4), 20'h00020);
        reg_write(ra(0, 4), 20'h00020);
        settle(3);
        expect_unit(20'h12342, 20'h00800, 1'b1, "R9");
        expect_unit(20'h12344, 20'h00800, 1'b1, "R9");
        allow = 1'b1;
        settle(40);
        drained("R9");
        check(events - ev0 == 4, "R9", "bus cycles for three requests", 40'(events - ev0), 40'h4);
        reg_check(ra(0, 5), 20'h00002, "R11", "count reloaded");
        reg_check(ra(0, 6), 20'h12340, "R11", "forward pointer back at base");
        reg_check(ra(0, 3), 20'h00007, "R11", "still enabled");
        check(done0 == 2, "R11", "ch0 completion pulses", 40'(done0), 40'h2);
        check(done1 == 0, "R10", "ch1 completion pulses", 40'(done1), 40'h0);

        summary();
        $finish;
    end
endmodule